// File: doc/BRIEF.md
# Configuration Frame Receiver and Checker

This block sits between a serial configuration source and the configuration memory of a programmable device. It takes one bit per clock whenever `bit_vld` is high. In front of each frame it skips a run of alignment ones, and it recognises a frame start as a 0 followed by a 1. It then collects a fixed number of data bits and an 8-bit checksum, and checks an eight-bit trailer of stop ones. A frame that passes every check is presented on a parallel write port for one cycle, together with a frame address. The address starts at zero and advances by one for each accepted frame.

The parameters fix the data bits per frame and the number of frames. One build serves the smaller device, with 502 bits and 2136 frames. Another serves the larger device, with 592 bits and 2520 frames. Any fault stops the block for good and raises a sticky error flag: a malformed start, a wrong checksum, or a zero in the trailer. Only a reset clears it. After the final frame is accepted, a single-cycle done pulse is raised and the rest of the stream is ignored.

Top module: `cfgrx_top`

## Requirements
- R1: While hunting for a frame, ones with `bit_vld` high are skipped as alignment. The first 0 followed by a 1 starts a frame, and the next valid bit is data bit 0.
- R2: A 0 followed by a 0 while a start is expected sets `err` one cycle after the second 0 is sampled.
- R3: Each frame carries DATA_BITS data bits. In the written word, `wr_data[k]` is the k-th data bit received.
- R4: Eight checksum bits follow the data, least significant first. Checksum bit j must equal the XOR of every data bit k with k mod 8 = j. This is the same as the bytewise XOR of the data zero-padded to whole bytes, with data bit k at bit k mod 8 of byte k/8. A mismatch sets `err` and the frame is not written.
- R5: Eight stop bits follow the checksum, and each must be 1. A 0 in any of them sets `err` and the frame is not written.
- R6: An accepted frame raises `wr_en` for exactly one cycle, the cycle after the clock edge that samples its last stop bit. `wr_addr` is 0 for the first frame and one more for each frame after it.
- R7: `err` is sticky until reset. While it is high, no write occurs, whatever the input.
- R8: `done` is high for exactly one cycle, together with the write of frame NUM_FRAMES-1. All input after that is ignored.
- R9: Cycles with `bit_vld` low are ignored, whatever `bit_in` holds, so the stream may pause anywhere.
- R10: After reset, `wr_en`, `done` and `err` are 0 and `wr_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | `bit_in` holds a stream bit this cycle |
| bit_in | input | 1 | Serial stream bit |
| wr_en | output | 1 | One-cycle write strobe for an accepted frame |
| wr_addr | output | AW (clog2 of NUM_FRAMES) | Frame address of the write |
| wr_data | output | DATA_BITS | Data bits of the accepted frame, first received at bit 0 |
| done | output | 1 | One-cycle pulse when the final frame is written |
| err | output | 1 | Sticky fault flag |

## Verification
The assertions watch every cycle for the following:
- the write strobe is a single-cycle pulse;
- the address steps by exactly one after each write and holds steady otherwise;
- the error flag never clears, and never coincides with a write;
- done arrives only with the write to the last address, and the finished and faulted states are never left.

Only the bench scenarios can show the rest:
- that the checksum bit lanes, the bit order in the written word and the alignment skipping are correct;
- that the write lands exactly one cycle after the last stop bit;
- that each kind of malformed frame blocks its write.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;
  localparam int CKS_W  = 8;
  localparam int STOP_W = 8;

  typedef enum logic [2:0] {
    S_HUNT,
    S_SAW0,
    S_DATA,
    S_CHK,
    S_STOP,
    S_FIN,
    S_ERR
  } rx_state_t;

  // fold one data bit into its checksum lane (lane = bit index mod 8)
  function automatic logic [CKS_W-1:0] cks_fold(input logic [CKS_W-1:0] acc,
                                               input logic [2:0] lane,
                                               input logic b);
    logic [CKS_W-1:0] r;
    r       = acc;
    r[lane] = r[lane] ^ b;
    return r;
  endfunction
endpackage

// File: rtl/cfgrx_seq.sv
module cfgrx_seq
  import cfgrx_pkg::*;
#(
  parameter int DATA_BITS = 502
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic cks_match,
  input  logic last_frame,
  output logic shift_data,
  output logic shift_chk,
  output logic ev_start,
  output logic ev_accept,
  output logic ev_bad_start,
  output logic ev_bad_cks,
  output logic ev_bad_stop
);
  localparam int CW = (DATA_BITS > 8) ? $clog2(DATA_BITS) : 3;
  localparam logic [CW-1:0] LAST_D = CW'(DATA_BITS - 1);
  localparam logic [CW-1:0] LAST_8 = CW'(CKS_W - 1);

  rx_state_t st_q, nxt;
  logic [CW-1:0] cnt_q;
  logic counting;

  always_comb begin
    nxt          = st_q;
    counting     = 1'b0;
    shift_data   = 1'b0;
    shift_chk    = 1'b0;
    ev_start     = 1'b0;
    ev_accept    = 1'b0;
    ev_bad_start = 1'b0;
    ev_bad_cks   = 1'b0;
    ev_bad_stop  = 1'b0;
    case (st_q)
      S_HUNT: if (bit_vld && !bit_in) nxt = S_SAW0;
      S_SAW0: if (bit_vld) begin
        if (bit_in) begin
          nxt      = S_DATA;
          ev_start = 1'b1;
        end else begin
          nxt          = S_ERR;
          ev_bad_start = 1'b1;
        end
      end
      S_DATA: if (bit_vld) begin
        shift_data = 1'b1;
        counting   = 1'b1;
        if (cnt_q == LAST_D) nxt = S_CHK;
      end
      S_CHK: if (bit_vld) begin
        shift_chk = 1'b1;
        counting  = 1'b1;
        if (cnt_q == LAST_8) nxt = S_STOP;
      end
      S_STOP: if (bit_vld) begin
        counting = 1'b1;
        if (!bit_in) begin
          nxt         = S_ERR;
          ev_bad_stop = 1'b1;
        end else if (cnt_q == LAST_8) begin
          if (cks_match) begin
            ev_accept = 1'b1;
            nxt       = last_frame ? S_FIN : S_HUNT;
          end else begin
            ev_bad_cks = 1'b1;
            nxt        = S_ERR;
          end
        end
      end
      default: nxt = st_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_HUNT;
      cnt_q <= '0;
    end else begin
      st_q <= nxt;
      if (nxt != st_q)   cnt_q <= '0;
      else if (counting) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8: the finished state is never left
  a_r8_fin_holds: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == S_FIN |=> st_q == S_FIN);
  // R7: the fault state is never left
  a_r7_err_state_holds: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == S_ERR |=> st_q == S_ERR);
  // R9: an idle cycle leaves the sequence where it was
  a_r9_idle_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> st_q == $past(st_q));
endmodule

// File: rtl/cfgrx_datapath.sv
module cfgrx_datapath
  import cfgrx_pkg::*;
#(
  parameter int DATA_BITS = 502
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_in,
  input  logic                 clear,
  input  logic                 shift_data,
  input  logic                 shift_chk,
  output logic [DATA_BITS-1:0] data,
  output logic                 cks_match
);
  logic [DATA_BITS-1:0] data_q;
  logic [CKS_W-1:0]     acc_q;
  logic [CKS_W-1:0]     rxc_q;
  logic [2:0]           lane_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      acc_q  <= '0;
      rxc_q  <= '0;
      lane_q <= '0;
    end else begin
      if (clear) begin
        acc_q  <= '0;
        lane_q <= '0;
      end else if (shift_data) begin
        acc_q  <= cks_fold(acc_q, lane_q, bit_in);
        lane_q <= lane_q + 1'b1;
      end
      if (shift_data) data_q <= {bit_in, data_q[DATA_BITS-1:1]};
      if (shift_chk)  rxc_q  <= {bit_in, rxc_q[CKS_W-1:1]};
    end
  end

  assign data      = data_q;
  assign cks_match = (acc_q == rxc_q);

  // R3: data shifting and checksum capture never overlap
  a_r3_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_data && shift_chk));
endmodule

// File: rtl/cfgrx_frame_ctr.sv
module cfgrx_frame_ctr #(
  parameter int NUM_FRAMES = 2136,
  localparam int AW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_accept,
  output logic          last_frame,
  output logic          wr_en,
  output logic          done,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = AW'(NUM_FRAMES - 1);

  logic [AW-1:0] addr_q;
  logic          wr_q, done_q;

  assign last_frame = (addr_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      wr_q   <= ev_accept;
      done_q <= ev_accept && last_frame;
      if (wr_q && !last_frame) addr_q <= addr_q + 1'b1;
    end
  end

  assign wr_en = wr_q;
  assign done  = done_q;
  assign addr  = addr_q;

  // R6: address steps by one after each non-final write
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q && !done_q |=> addr_q == $past(addr_q) + 1'b1);
  // R6: address holds without a write
  a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_q |=> $stable(addr_q));
endmodule

// File: rtl/cfgrx_top.sv
module cfgrx_top #(
  parameter int DATA_BITS  = 502,
  parameter int NUM_FRAMES = 2136,
  localparam int AW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_vld,
  input  logic                 bit_in,
  output logic                 wr_en,
  output logic [AW-1:0]        wr_addr,
  output logic [DATA_BITS-1:0] wr_data,
  output logic                 done,
  output logic                 err
);
  localparam logic [AW-1:0] LAST = AW'(NUM_FRAMES - 1);

  logic shift_data, shift_chk, cks_match, last_frame;
  logic ev_start, ev_accept, ev_bad_start, ev_bad_cks, ev_bad_stop;
  logic err_q;

  cfgrx_seq #(.DATA_BITS(DATA_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .cks_match(cks_match), .last_frame(last_frame),
    .shift_data(shift_data), .shift_chk(shift_chk),
    .ev_start(ev_start), .ev_accept(ev_accept),
    .ev_bad_start(ev_bad_start), .ev_bad_cks(ev_bad_cks),
    .ev_bad_stop(ev_bad_stop)
  );

  cfgrx_datapath #(.DATA_BITS(DATA_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .clear(ev_start),
    .shift_data(shift_data), .shift_chk(shift_chk),
    .data(wr_data), .cks_match(cks_match)
  );

  cfgrx_frame_ctr #(.NUM_FRAMES(NUM_FRAMES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .ev_accept(ev_accept),
    .last_frame(last_frame), .wr_en(wr_en), .done(done), .addr(wr_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q | ev_bad_start | ev_bad_cks | ev_bad_stop;
  end
  assign err = err_q;

  // R7: error is sticky
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R7: no write while faulted
  a_r7_no_write_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !wr_en);
  // R6: write strobe lasts one cycle
  a_r6_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R8: done only with the write of the final address
  a_r8_done_with_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> wr_en && wr_addr == LAST);
  // R8: done is a single pulse
  a_r8_done_once: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3: written word is stable while presented
  a_r3_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $stable(wr_data));
endmodule

// File: tb/cfgrx_top_tb.sv
module cfgrx_top_tb;
  localparam int DB = 20;
  localparam int NF = 3;
  localparam int AW = $clog2(NF);
  localparam int NV = 4;
  localparam logic [DB-1:0] V_SEED  [NV] = '{20'hA5C3F, 20'h00000, 20'hFFFFF, 20'h3C96E};
  localparam int            V_ALIGN [NV] = '{0, 3, 1, 7};
  localparam bit            V_GAP   [NV] = '{1'b0, 1'b0, 1'b1, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic wr_en, done, err;
  logic [AW-1:0] wr_addr;
  logic [DB-1:0] wr_data;

  cfgrx_top #(.DATA_BITS(DB), .NUM_FRAMES(NF)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .err(err)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nfail = 0;
  int n_wr, n_done, done_cyc, last_stop_cyc;
  logic [DB-1:0] log_d [8];
  int log_a [8];
  int log_c [8];

  always @(negedge clk) begin
    if (!rst_n) begin
      n_wr   = 0;
      n_done = 0;
    end else begin
      if (wr_en && n_wr < 8) begin
        log_d[n_wr] = wr_data;
        log_a[n_wr] = int'(wr_addr);
        log_c[n_wr] = cyc;
        n_wr = n_wr + 1;
      end
      if (done) begin
        n_done   = n_done + 1;
        done_cyc = cyc;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_vld = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drive(input logic b, input bit gap);
    @(negedge clk);
    bit_vld = 1'b1; bit_in = b;
    if (gap) begin
      @(negedge clk);
      bit_vld = 1'b0; bit_in = ~b;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bit_vld = 1'b0; bit_in = ~bit_in;
    end
  endtask

  // bytewise checksum of zero-padded data
  function automatic logic [7:0] bytes_xor(input logic [DB-1:0] d);
    logic [8*((DB+7)/8)-1:0] pad;
    logic [7:0] c;
    pad = '0;
    pad[DB-1:0] = d;
    c = 8'h00;
    for (int b = 0; b < (DB+7)/8; b++) c = c ^ pad[8*b +: 8];
    return c;
  endfunction

  // fault: 0 none, 1 flip checksum bit 5, 2 zero at stop bit 3
  task automatic send_frame(input logic [DB-1:0] d, input int align, input bit gap, input int fault);
    logic [7:0] c;
    c = bytes_xor(d);
    if (fault == 1) c[5] = ~c[5];
    for (int i = 0; i < align; i++) drive(1'b1, gap);
    drive(1'b0, gap);
    drive(1'b1, gap);
    for (int k = 0; k < DB; k++) drive(d[k], gap);
    for (int j = 0; j < 8; j++) drive(c[j], gap);
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      bit_vld = 1'b1; bit_in = !(fault == 2 && s == 3);
      last_stop_cyc = cyc;
      if (gap) begin
        @(negedge clk);
        bit_vld = 1'b0; bit_in = 1'b0;
      end
    end
    idle(2);
  endtask

  function automatic logic [DB-1:0] fdata(input logic [DB-1:0] seed, input int i);
    return seed ^ (DB'(i) * 20'h2D6B1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_up();
  end

  initial begin
    // R10: reset state
    do_reset();
    @(negedge clk);
    check(!wr_en && !done && !err, "R10 reset outputs", {wr_en, done, err}, 0);
    check(wr_addr == 0, "R10 reset address", 64'(wr_addr), 0);

    // table walk: R1 alignment, R3 data order, R4 checksum, R6 write, R8 done, R9 gaps
    for (int v = 0; v < NV; v++) begin
      do_reset();
      for (int i = 0; i < NF; i++) begin
        send_frame(fdata(V_SEED[v], i), V_ALIGN[v] + i, V_GAP[v], 0);
        check(n_wr == i + 1, "R1/R4 frame accepted", 64'(n_wr), 64'(i + 1));
        if (n_wr == i + 1) begin
          check(log_a[i] == i, "R6 write address", 64'(log_a[i]), 64'(i));
          check(log_d[i] == fdata(V_SEED[v], i), "R3 R9 written data", 64'(log_d[i]), 64'(fdata(V_SEED[v], i)));
          check(log_c[i] == last_stop_cyc + 1, "R6 write timing", 64'(log_c[i]), 64'(last_stop_cyc + 1));
        end
      end
      check(n_done == 1, "R8 one done pulse", 64'(n_done), 1);
      check(done_cyc == log_c[NF-1], "R8 done with final write", 64'(done_cyc), 64'(log_c[NF-1]));
      check(!err, "R7 no error on good stream", 64'(err), 0);
    end

    // R8: input after done is ignored
    send_frame(20'h12345, 0, 1'b0, 0);
    check(n_wr == NF && n_done == 1 && !err, "R8 post-done ignored", 64'(n_wr), 64'(NF));

    // R4: checksum mismatch blocks the write, then R7 sticky
    do_reset();
    send_frame(20'h0F0F0, 2, 1'b0, 0);
    send_frame(20'h11111, 0, 1'b0, 1);
    check(n_wr == 1, "R4 bad checksum not written", 64'(n_wr), 1);
    check(err, "R4 bad checksum flags error", 64'(err), 1);
    send_frame(20'h22222, 0, 1'b0, 0);
    check(n_wr == 1 && err, "R7 sticky, no write after error", 64'(n_wr), 1);

    // R5: zero among stop bits
    do_reset();
    send_frame(20'h5A5A5, 1, 1'b0, 2);
    check(n_wr == 0, "R5 bad stop not written", 64'(n_wr), 0);
    check(err, "R5 bad stop flags error", 64'(err), 1);

    // R7 / R10: reset clears the error
    do_reset();
    @(negedge clk);
    check(!err && wr_addr == 0, "R10 reset clears error", 64'(err), 0);

    // R2: 0 then 0 is a bad start; error one cycle after second 0
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b0);
    @(negedge clk);
    bit_vld = 1'b0;
    check(err, "R2 bad start flags error", 64'(err), 1);
    send_frame(20'hABCDE, 0, 1'b0, 0);
    check(n_wr == 0, "R2 R7 no write after bad start", 64'(n_wr), 0);

    // R9: garbage with bit_vld low while hunting does not start a frame
    do_reset();
    for (int g = 0; g < 6; g++) begin
      @(negedge clk);
      bit_vld = 1'b0; bit_in = g[0];
    end
    send_frame(20'h0000F, 0, 1'b0, 0);
    check(n_wr == 1 && log_d[0] == 20'h0000F && !err, "R9 idle garbage ignored", 64'(log_d[0]), 64'h0000F);

    finish_up();
  end
endmodule